// File: doc/BRIEF.md
# Reference-Counted Physical Register Allocator

This block looks after the physical register pool of a small out-of-order core that eliminates register moves. Because an eliminated move makes two architectural names point at one physical register, a register cannot be recycled when a single instruction retires. Each physical register therefore keeps a small reference count of the reorder-buffer and rename-table entries that point at it. The register is taken off the free list when its count leaves zero, and it goes back on the free list when its count returns to zero.

Every cycle, four request lanes may each add or drop one reference to a named register, and several lanes may name the same register. A separate set of four commit lanes keeps a committed copy of every counter up to date as instructions retire. On a flush, the committed copy overwrites the speculative counters and the free list is rebuilt from it. The rename stage reads the free-list head to choose the next fresh register, and claims it by sending an allocate request for that register.

Top module: `rcpra_alloc`

## Requirements
- R1: After reset, registers 0..7 hold one reference each and registers 8..15 hold none. The free list holds 8..15 in ascending order: head 8, count 8.
- R2: An allocate of a register whose count is zero removes it from the free list. That register must be the current head, at most one such register is taken per cycle, the head moves to the next entry and the count falls by one.
- R3: An allocate of a register whose count is already nonzero (a shared mapping) leaves the free list unchanged. The register returns to the free list only once every reference has been dropped.
- R4: A deallocate that brings a count to zero appends the register at the free-list tail. When several registers reach zero in one cycle, they are appended in order of their request lane, lowest lane first.
- R5: Requests to one register in the same cycle are merged into one net change, written by the lowest-numbered lane that names it. A net change of zero leaves both the count and the free list unchanged: dropping register 0 while adding register 0 and register 9 leaves register 0 at one and gives register 9 one.
- R6: Counters are 3 bits wide. They saturate at 7 on increment and never go below zero.
- R7: Commit lanes update only the committed counters. They change neither the speculative counters nor the free list.
- R8: On flush, the speculative counters take the committed values, including commits in the flush cycle. The free list is rebuilt with every register whose committed count is zero, in ascending order. Requests in the flush cycle are ignored.
- R9: An allocate from the head and a deallocate to zero in the same cycle are both applied. The count is unchanged and the freed register lands at the tail.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_vld | input | 4 | Speculative request lane valid |
| req_alloc | input | 4 | Per lane: 1 adds a reference, 0 drops one |
| req_preg | input | 16 | Per lane register id, lane n in bits [4n+3:4n] |
| cmt_vld | input | 4 | Commit lane valid |
| cmt_alloc | input | 4 | Per commit lane: 1 adds a reference, 0 drops one |
| cmt_preg | input | 16 | Per commit lane register id, lane n in bits [4n+3:4n] |
| flush | input | 1 | Restore speculative state from the committed copy |
| fl_head | output | 4 | Register id at the free-list head |
| fl_count | output | 5 | Number of registers on the free list |

## Verification
The bench sends four requests to one register that cancel out, and repeats the mixed example. A design that added the lanes separately, or let a higher lane overwrite the count, would free or strand the register on the next single deallocate. It saturates a counter with eight increments and then shows that seven decrements free it. A wrapping counter would need a different number of decrements, and the free count would show the difference. It frees three registers in one cycle, drains the whole list and checks the pop order, which exposes any wrong lane ordering or tail arithmetic. It also issues a flush in the same cycle as a commit, which catches a rebuild that uses the stale committed copy.

// File: rtl/pra_pkg.sv
package pra_pkg;
    localparam int PR_NUM = 16;  // one physical register per reorder entry
    localparam int REQ_N  = 4;   // request lanes per cycle
    localparam int CNT_W  = 3;   // reference counter width
    localparam int ARCH_N = 8;   // registers holding architectural state at reset
endpackage

// File: rtl/pra_adders.sv
// Bank of per-lane adders: lane n totals every same-cycle request that names
// its register and proposes a saturated new count; the lowest lane wins.
module pra_adders #(
    parameter int NPREG = 16,
    parameter int NREQ  = 4,
    parameter int CW    = 3,
    localparam int IDW  = $clog2(NPREG)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NPREG-1:0][CW-1:0]     cnt_i,
    input  logic [NREQ-1:0]              vld_i,
    input  logic [NREQ-1:0]              alloc_i,
    input  logic [NREQ-1:0][IDW-1:0]     preg_i,
    output logic [NREQ-1:0]              wr_o,
    output logic [NREQ-1:0][CW-1:0]      old_o,
    output logic [NREQ-1:0][CW-1:0]      new_o
);
    localparam int SW = CW + $clog2(NREQ) + 2;
    localparam logic signed [SW-1:0] ONE  = SW'(1);
    localparam logic signed [SW-1:0] SMAX = SW'((1 << CW) - 1);

    for (genvar n = 0; n < NREQ; n++) begin : g_lane
        logic signed [SW-1:0] net;
        logic signed [SW-1:0] sum;
        logic                 first;

        always_comb begin
            net   = '0;
            first = vld_i[n];
            for (int j = 0; j < NREQ; j++) begin
                if (vld_i[j] && (preg_i[j] == preg_i[n])) begin
                    net = alloc_i[j] ? (net + ONE) : (net - ONE);
                    if (j < n) first = 1'b0;
                end
            end
            old_o[n] = cnt_i[preg_i[n]];
            sum      = $signed({{(SW-CW){1'b0}}, cnt_i[preg_i[n]]}) + net;
            if (sum < 0)
                new_o[n] = '0;
            else if (sum > SMAX)
                new_o[n] = {CW{1'b1}};
            else
                new_o[n] = sum[CW-1:0];
            wr_o[n] = first;
        end

        // R6: a write never asks for a count below zero
        a_r6_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
            wr_o[n] |-> (sum >= 0));
    end
endmodule

// File: rtl/pra_freelist.sv
// Circular FIFO of free register ids: one pop, up to NREQ ordered pushes,
// full rebuild from a mask on flush.
module pra_freelist #(
    parameter int NPREG = 16,
    parameter int NREQ  = 4,
    parameter int NARCH = 8,
    localparam int IDW  = $clog2(NPREG),
    localparam int CNTW = $clog2(NPREG) + 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      flush_i,
    input  logic [NPREG-1:0]          rebuild_free_i,
    input  logic                      pop_i,
    input  logic [NREQ-1:0]           push_vld_i,
    input  logic [NREQ-1:0][IDW-1:0]  push_id_i,
    output logic [IDW-1:0]            head_o,
    output logic [CNTW-1:0]           count_o
);
    typedef struct packed {
        logic [NPREG-1:0][IDW-1:0] slot;
        logic [IDW-1:0]            hd;
        logic [IDW-1:0]            tl;
        logic [CNTW-1:0]           cnt;
    } fl_t;

    fl_t fl_d, fl_q;

    always_comb begin
        logic [CNTW-1:0] k;
        fl_d = fl_q;
        k    = '0;
        if (flush_i) begin
            for (int i = 0; i < NPREG; i++) begin
                if (rebuild_free_i[i]) begin
                    fl_d.slot[k[IDW-1:0]] = IDW'(i);
                    k = k + 1'b1;
                end
            end
            fl_d.hd  = '0;
            fl_d.tl  = k[IDW-1:0];
            fl_d.cnt = k;
        end else begin
            if (pop_i) fl_d.hd = fl_q.hd + 1'b1;
            for (int n = 0; n < NREQ; n++) begin
                if (push_vld_i[n]) begin
                    fl_d.slot[fl_q.tl + k[IDW-1:0]] = push_id_i[n];
                    k = k + 1'b1;
                end
            end
            fl_d.tl  = fl_q.tl + k[IDW-1:0];
            fl_d.cnt = fl_q.cnt - CNTW'(pop_i) + k;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NPREG; i++)
                fl_q.slot[i] <= (i < NPREG - NARCH) ? IDW'(i + NARCH) : '0;
            fl_q.hd  <= '0;
            fl_q.tl  <= IDW'(NPREG - NARCH);
            fl_q.cnt <= CNTW'(NPREG - NARCH);
        end else begin
            fl_q <= fl_d;
        end
    end

    assign head_o  = fl_q.slot[fl_q.hd];
    assign count_o = fl_q.cnt;

    // R2: a register is only taken from a non-empty list
    a_r2_pop_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !flush_i) |-> (fl_q.cnt != '0));
    // R4: returns never overfill the list
    a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        !flush_i |-> ((int'(fl_q.cnt) - int'(pop_i) + $countones(push_vld_i)) <= NPREG));
    // R8: after a flush the list holds exactly the registers marked free
    a_r8_rebuild_count: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (int'(count_o) == $countones($past(rebuild_free_i))));
endmodule

// File: rtl/rcpra_alloc.sv
module rcpra_alloc
    import pra_pkg::*;
#(
    parameter int NPREG = PR_NUM,
    parameter int NREQ  = REQ_N,
    parameter int CW    = CNT_W,
    parameter int NARCH = ARCH_N,
    localparam int IDW  = $clog2(NPREG),
    localparam int CNTW = $clog2(NPREG) + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NREQ-1:0]      req_vld,
    input  logic [NREQ-1:0]      req_alloc,
    input  logic [NREQ*IDW-1:0]  req_preg,
    input  logic [NREQ-1:0]      cmt_vld,
    input  logic [NREQ-1:0]      cmt_alloc,
    input  logic [NREQ*IDW-1:0]  cmt_preg,
    input  logic                 flush,
    output logic [IDW-1:0]       fl_head,
    output logic [CNTW-1:0]      fl_count
);
    typedef struct packed {
        logic [NPREG-1:0][CW-1:0] spec;
        logic [NPREG-1:0][CW-1:0] cmt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    logic [NREQ-1:0][IDW-1:0] rq_id, cm_id;
    logic [NREQ-1:0]          sp_wr, cm_wr;
    logic [NREQ-1:0][CW-1:0]  sp_old, sp_new, cm_old, cm_new;
    logic [NREQ-1:0]          became_busy, became_free;
    logic [NPREG-1:0]         rebuild_free;
    logic                     pop;

    for (genvar n = 0; n < NREQ; n++) begin : g_unpack
        assign rq_id[n] = req_preg[n*IDW +: IDW];
        assign cm_id[n] = cmt_preg[n*IDW +: IDW];
        assign became_busy[n] = sp_wr[n] && !flush && (sp_old[n] == '0) && (sp_new[n] != '0);
        assign became_free[n] = sp_wr[n] && !flush && (sp_old[n] != '0) && (sp_new[n] == '0);

        // R2: a fresh register can only be the one at the head
        a_r2_take_head: assert property (@(posedge clk) disable iff (!rst_n)
            became_busy[n] |-> (rq_id[n] == fl_head));
    end

    pra_adders #(.NPREG(NPREG), .NREQ(NREQ), .CW(CW)) u_spec_add (
        .clk(clk), .rst_n(rst_n), .cnt_i(st_q.spec),
        .vld_i(req_vld), .alloc_i(req_alloc), .preg_i(rq_id),
        .wr_o(sp_wr), .old_o(sp_old), .new_o(sp_new)
    );

    pra_adders #(.NPREG(NPREG), .NREQ(NREQ), .CW(CW)) u_cmt_add (
        .clk(clk), .rst_n(rst_n), .cnt_i(st_q.cmt),
        .vld_i(cmt_vld), .alloc_i(cmt_alloc), .preg_i(cm_id),
        .wr_o(cm_wr), .old_o(cm_old), .new_o(cm_new)
    );

    always_comb begin
        st_d = st_q;
        for (int n = NREQ - 1; n >= 0; n--) begin
            if (cm_wr[n]) st_d.cmt[cm_id[n]] = cm_new[n];
            if (sp_wr[n] && !flush) st_d.spec[rq_id[n]] = sp_new[n];
        end
        if (flush) st_d.spec = st_d.cmt;
        for (int i = 0; i < NPREG; i++)
            rebuild_free[i] = (st_d.cmt[i] == '0);
    end

    assign pop = |became_busy;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NPREG; i++) begin
                st_q.spec[i] <= (i < NARCH) ? CW'(1) : '0;
                st_q.cmt[i]  <= (i < NARCH) ? CW'(1) : '0;
            end
        end else begin
            st_q <= st_d;
        end
    end

    pra_freelist #(.NPREG(NPREG), .NREQ(NREQ), .NARCH(NARCH)) u_fl (
        .clk(clk), .rst_n(rst_n), .flush_i(flush),
        .rebuild_free_i(rebuild_free), .pop_i(pop),
        .push_vld_i(became_free), .push_id_i(rq_id),
        .head_o(fl_head), .count_o(fl_count)
    );

    // R2: at most one register leaves the free list per cycle
    a_r2_single_take: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(became_busy) <= 1);
    // R7: with no speculative request and no flush the speculative counters hold
    a_r7_spec_isolated: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && (req_vld == '0)) |=> $stable(st_q.spec));
endmodule

// File: tb/tb_rcpra_alloc.sv
module tb_rcpra_alloc;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  req_vld, req_alloc, cmt_vld, cmt_alloc;
    logic [15:0] req_preg, cmt_preg;
    logic        flush;
    logic [3:0]  fl_head;
    logic [4:0]  fl_count;
    int          n_chk = 0;
    int          n_bad = 0;

    always #4 clk = ~clk;

    rcpra_alloc dut (
        .clk(clk), .rst_n(rst_n),
        .req_vld(req_vld), .req_alloc(req_alloc), .req_preg(req_preg),
        .cmt_vld(cmt_vld), .cmt_alloc(cmt_alloc), .cmt_preg(cmt_preg),
        .flush(flush), .fl_head(fl_head), .fl_count(fl_count)
    );

    task automatic clr();
        req_vld = '0; req_alloc = '0; req_preg = '0;
        cmt_vld = '0; cmt_alloc = '0; cmt_preg = '0;
        flush = 1'b0;
    endtask

    task automatic lane(int n, bit a, int id);
        req_vld[n] = 1'b1; req_alloc[n] = a; req_preg[n*4 +: 4] = 4'(id);
    endtask

    task automatic clane(int n, bit a, int id);
        cmt_vld[n] = 1'b1; cmt_alloc[n] = a; cmt_preg[n*4 +: 4] = 4'(id);
    endtask

    task automatic step();
        @(posedge clk); @(negedge clk); clr();
    endtask

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic take_head(string tag, int exp_id);
        chk(tag, fl_head, exp_id);
        lane(0, 1'b1, fl_head);
        step();
    endtask

    task automatic t_reset();
        chk("R1 head", fl_head, 8);
        chk("R1 count", fl_count, 8);
    endtask

    task automatic t_share();
        lane(0, 1'b1, 8); step();
        chk("R2 head after take", fl_head, 9);
        chk("R2 count after take", fl_count, 7);
        lane(0, 1'b1, 8); step();
        chk("R3 shared alloc count", fl_count, 7);
        lane(0, 1'b0, 8); step();
        chk("R3 one drop still held", fl_count, 7);
        lane(0, 1'b0, 8); step();
        chk("R3 last drop frees", fl_count, 8);
    endtask

    task automatic t_merge();
        lane(0, 1'b0, 0); lane(1, 1'b1, 0); lane(2, 1'b1, 9); step();
        chk("R5 mixed head", fl_head, 10);
        chk("R5 mixed count", fl_count, 7);
        lane(3, 1'b0, 0); step();
        chk("R5 reg0 stayed at one", fl_count, 8);
        lane(0, 1'b1, 1); lane(1, 1'b1, 1); lane(2, 1'b0, 1); lane(3, 1'b0, 1); step();
        chk("R5 four-way cancel", fl_count, 8);
        lane(2, 1'b0, 1); step();
        chk("R5 reg1 stayed at one", fl_count, 9);
    endtask

    task automatic t_multi_free();
        lane(0, 1'b0, 4); lane(1, 1'b0, 2); lane(2, 1'b0, 3); step();
        chk("R4 three freed", fl_count, 12);
        for (int i = 10; i < 16; i++) take_head("R4 drain old", i);
        take_head("R4 order 8", 8);
        take_head("R4 order 0", 0);
        take_head("R4 order 1", 1);
        take_head("R4 order lane0", 4);
        take_head("R4 order lane1", 2);
        take_head("R4 order lane2", 3);
        chk("R2 list empty", fl_count, 0);
    endtask

    task automatic t_saturate();
        for (int r = 0; r < 2; r++) begin
            for (int n = 0; n < 4; n++) lane(n, 1'b1, 5);
            step();
        end
        for (int n = 0; n < 4; n++) lane(n, 1'b0, 5);
        step();
        chk("R6 seven minus four held", fl_count, 0);
        lane(0, 1'b0, 5); lane(1, 1'b0, 5); step();
        chk("R6 one left held", fl_count, 0);
        lane(0, 1'b0, 5); step();
        chk("R6 seventh drop frees", fl_count, 1);
        chk("R6 freed id", fl_head, 5);
    endtask

    task automatic t_swap();
        lane(0, 1'b1, 5); lane(1, 1'b0, 6); step();
        chk("R9 count", fl_count, 1);
        chk("R9 head", fl_head, 6);
    endtask

    task automatic t_flush();
        clane(0, 1'b1, 8); step();
        chk("R7 commit leaves count", fl_count, 1);
        chk("R7 commit leaves head", fl_head, 6);
        clane(1, 1'b0, 0); flush = 1'b1; lane(0, 1'b1, 6); step();
        chk("R8 rebuilt count", fl_count, 8);
        chk("R8 rebuilt head", fl_head, 0);
        take_head("R8 first entry", 0);
        chk("R8 next entry", fl_head, 9);
        chk("R8 count after take", fl_count, 7);
    endtask

    initial begin
        #(8 * 100000);
        n_bad++;
        $display("FAIL watchdog: actual 0 expected 1");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
        $finish;
    end

    initial begin
        clr();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_share();
        t_merge();
        t_multi_free();
        t_saturate();
        t_swap();
        t_flush();
        $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
        $finish;
    end
endmodule